// File: doc/BRIEF.md
# Host OUT Endpoint Controller

This block holds the control and status state of one transmit (OUT) endpoint in a USB host controller. Software programs a transfer-type register (speed, protocol, target endpoint number), a maximum packet size and a NAK limit. It then fills the endpoint's transmit FIFO a byte at a time. The block counts the bytes loaded into the current buffer. It marks a buffer as ready for sending, either when software asks or automatically once the count reaches the maximum packet size, and it tracks how many committed packets the single- or double-buffered FIFO holds. It owns the data toggle used by the packet engine: normal flipping after each successful transaction, a forced mode, a guarded direct write and a clear strobe.

The packet engine reports each acknowledged transaction on `xact_done` and each NAK on `nak_seen`. It sends while `tx_pending` is high. A frame tick drives a NAK counter that raises a sticky timeout flag after the programmed number of frames without success. Byte loading is a valid/ready stream with no data payload, because the bytes go to the FIFO RAM elsewhere. A byte counts only in a cycle where `ld_valid` and `ld_ready` are both high. `ld_ready` stays low while the transmit direction has not been given the FIFO or all buffers are committed. The source may hold `ld_valid` through back-pressure. The other pins are plain levels or single-cycle strobes.

Register map (`reg_addr`): 0 control/status, 1 transfer type, 2 max packet size, 3 NAK limit. Reads are combinational; writes take effect at the clock edge where `reg_wr` is high.

Top module: `host_out_ep`

## Requirements
- R1: After reset, every register reads 0, the toggle is 0, `tx_pending`, `nak_timeout` and `ld_ready` are 0.
- R2: Control/status bits 15..10 (auto-commit enable, isochronous select, FIFO-to-transmit mode, DMA enable, force toggle, DMA mode) are stored and read back. The max packet size keeps its low MAXP_W bits and the NAK limit keeps its low NAK_W bits.
- R3: `ld_ready` is 1 only when control/status bit 13 is 1 and fewer than NBUF packets are committed. Load strobes without `ld_ready` are not counted.
- R4: With control/status bit 15 set, the accepted byte that brings the current buffer's count to the max packet size commits that buffer at the same clock edge.
- R5: Writing 1 to control/status bit 0 commits the current buffer when one is free. Bit 0 reads 1 when all NBUF buffers are committed. Bit 1 and `tx_pending` read 1 when at least one packet is committed.
- R6: Each `xact_done` pulse retires one committed packet. The toggle flips on each `xact_done` pulse.
- R7: With control/status bit 11 set, the toggle also flips on every `nak_seen` pulse; with it clear, NAKs leave the toggle unchanged.
- R8: Control/status bit 8 reads the toggle. A write loads bit 8 into the toggle only when bit 9 is 1 in the same write. Bit 9 reads 0.
- R9: Writing 1 to control/status bit 6 clears the toggle and overrides a toggle write in the same cycle. Bit 6 reads 0.
- R10: Each write of 1 to control/status bit 3 discards one committed packet, so two are needed with two buffers full. When none is committed, it discards the partial byte count instead.
- R11: Once a NAK is seen, frame ticks are counted until an `xact_done`, which restarts the count. `nak_timeout` rises at the tick that reaches the NAK limit; a limit of 0 disables it.
- R12: `nak_timeout`, read as control/status bit 7, stays set until software writes 1 to bit 7.
- R13: Transfer-type bits 3:0 drive `tgt_ep` and bits 7:6 drive `tgt_speed`. `bulk_sel` is 1 exactly when bits 5:4 equal 10b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| ld_valid | input | 1 | FIFO byte-load request |
| ld_ready | output | 1 | FIFO can accept a byte |
| xact_done | input | 1 | Packet engine: transaction acknowledged |
| nak_seen | input | 1 | Packet engine: NAK received |
| frame_tick | input | 1 | One pulse per frame or microframe |
| tx_pending | output | 1 | At least one packet committed for sending |
| data_tog | output | 1 | Current data toggle |
| nak_timeout | output | 1 | Sticky NAK-timeout flag |
| tgt_ep | output | 4 | Target endpoint number |
| tgt_speed | output | 2 | Programmed speed field |
| bulk_sel | output | 1 | Protocol field selects bulk |

## Verification
The bench builds the block with two buffers, an 11-bit max-packet field and a 16-bit NAK limit. Two buffers bring the full-FIFO back-pressure, the pair of flushes and the split between packet-ready and FIFO-not-empty within reach. The max packet size is programmed to 4 and the NAK limit to 3, so auto-commit boundaries and timeouts are reached in a few cycles. The large field widths are still exercised through register readback and truncation.

// File: rtl/host_out_ep_pkg.sv
package host_out_ep_pkg;
  localparam logic [1:0] ADDR_CSR   = 2'd0;
  localparam logic [1:0] ADDR_TYPE  = 2'd1;
  localparam logic [1:0] ADDR_MAXP  = 2'd2;
  localparam logic [1:0] ADDR_NAKLIM = 2'd3;

  localparam int BIT_AUTO    = 15;
  localparam int BIT_FORCE   = 11;
  localparam int BIT_MODE    = 13;
  localparam int BIT_TOGWE   = 9;
  localparam int BIT_TOGVAL  = 8;
  localparam int BIT_NAKTO   = 7;
  localparam int BIT_CLRTOG  = 6;
  localparam int BIT_FLUSH   = 3;
  localparam int BIT_NEMPTY  = 1;
  localparam int BIT_PKTRDY  = 0;

  localparam logic [15:0] CSR_STORE_MASK = 16'hFC00;
  localparam logic [1:0]  PROTO_BULK     = 2'b10;

  typedef struct packed {
    logic [1:0] speed;
    logic [1:0] proto;
    logic [3:0] ep;
  } xfer_type_t;
endpackage

// File: rtl/hoe_buf_track.sv
module hoe_buf_track #(
  parameter int NBUF  = 2,
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             ld_valid,
  output logic             ld_ready,
  input  logic             autoset,
  input  logic [CNT_W-1:0] maxp,
  input  logic             sw_commit,
  input  logic             retire,
  input  logic             flush,
  output logic             all_full,
  output logic             non_empty
);
  localparam int HW = $clog2(NBUF + 1);

  logic [HW-1:0]    held;
  logic [CNT_W-1:0] fill, fill_inc;
  logic room, ld_fire, auto_commit, commit, drop;

  assign room        = held < HW'(NBUF);
  assign ld_ready    = fifo_en & room;
  assign ld_fire     = ld_valid & ld_ready;
  assign fill_inc    = fill + CNT_W'(1);
  assign auto_commit = ld_fire & autoset & (fill_inc == maxp);
  assign commit      = room & (sw_commit | auto_commit);
  assign drop        = (retire | flush) & (held != '0);
  assign all_full    = held == HW'(NBUF);
  assign non_empty   = held != '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held <= '0;
      fill <= '0;
    end else begin
      held <= held + HW'(commit) - HW'(drop);
      if (commit)
        fill <= '0;
      else if (flush && held == '0)
        fill <= '0;
      else if (ld_fire)
        fill <= fill_inc;
    end
  end

  assert_flush_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && held != '0 && !commit) |=> held == $past(held) - HW'(1));
  assert_no_load_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (held == HW'(NBUF)) |-> !ld_ready);
  assert_autoset_commits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_commit && room && !drop) |=> held != '0);
endmodule

// File: rtl/hoe_toggle.sv
module hoe_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic wr_en,
  input  logic wr_val,
  input  logic flip,
  output logic tog
);
  always_ff @(posedge clk) begin
    if (!rst_n)     tog <= 1'b0;
    else if (clr)   tog <= 1'b0;
    else if (wr_en) tog <= wr_val;
    else if (flip)  tog <= ~tog;
  end

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !tog);
  assert_guarded_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> tog == $past(wr_val));
  assert_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flip && !clr && !wr_en) |=> tog != $past(tog));
endmodule

// File: rtl/hoe_nak_timer.sv
module hoe_nak_timer #(
  parameter int LIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_tick,
  input  logic             nak_seen,
  input  logic             ok,
  input  logic [LIM_W-1:0] limit,
  input  logic             flag_clr,
  output logic             timeout
);
  logic             run, counting, hit;
  logic [LIM_W-1:0] cnt, cnt_inc;

  assign cnt_inc  = cnt + LIM_W'(1);
  assign counting = frame_tick & (run | nak_seen) & (limit != '0) & ~timeout & ~ok;
  assign hit      = counting & (cnt_inc >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run     <= 1'b0;
      cnt     <= '0;
      timeout <= 1'b0;
    end else begin
      if (ok) begin
        run <= 1'b0;
        cnt <= '0;
      end else begin
        if (nak_seen) run <= 1'b1;
        if (counting) cnt <= hit ? '0 : cnt_inc;
      end
      if (hit)           timeout <= 1'b1;
      else if (flag_clr) timeout <= 1'b0;
    end
  end

  assert_flag_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !flag_clr) |=> timeout);
  assert_zero_limit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (limit == '0 && !timeout) |=> !timeout);
endmodule

// File: rtl/host_out_ep.sv
module host_out_ep
  import host_out_ep_pkg::*;
#(
  parameter int NBUF   = 2,
  parameter int MAXP_W = 11,
  parameter int NAK_W  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        ld_valid,
  output logic        ld_ready,
  input  logic        xact_done,
  input  logic        nak_seen,
  input  logic        frame_tick,
  output logic        tx_pending,
  output logic        data_tog,
  output logic        nak_timeout,
  output logic [3:0]  tgt_ep,
  output logic [1:0]  tgt_speed,
  output logic        bulk_sel
);
  logic [15:0]       csr_q;
  xfer_type_t        type_q;
  logic [MAXP_W-1:0] maxp_q;
  logic [NAK_W-1:0]  naklim_q;
  logic csr_wr, all_full, non_empty, flip;
  logic [15:0] csr_view;

  assign csr_wr = reg_wr && reg_addr == ADDR_CSR;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr_q    <= '0;
      type_q   <= '0;
      maxp_q   <= '0;
      naklim_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        ADDR_CSR:  csr_q    <= reg_wdata & CSR_STORE_MASK;
        ADDR_TYPE: type_q   <= xfer_type_t'(reg_wdata[7:0]);
        ADDR_MAXP: maxp_q   <= reg_wdata[MAXP_W-1:0];
        default:   naklim_q <= reg_wdata[NAK_W-1:0];
      endcase
    end
  end

  hoe_buf_track #(.NBUF(NBUF), .CNT_W(MAXP_W)) u_buf (
    .clk, .rst_n,
    .fifo_en   (csr_q[BIT_MODE]),
    .ld_valid,
    .ld_ready,
    .autoset   (csr_q[BIT_AUTO]),
    .maxp      (maxp_q),
    .sw_commit (csr_wr & reg_wdata[BIT_PKTRDY]),
    .retire    (xact_done),
    .flush     (csr_wr & reg_wdata[BIT_FLUSH]),
    .all_full,
    .non_empty
  );

  assign flip = xact_done | (csr_q[BIT_FORCE] & nak_seen);

  hoe_toggle u_tog (
    .clk, .rst_n,
    .clr    (csr_wr & reg_wdata[BIT_CLRTOG]),
    .wr_en  (csr_wr & reg_wdata[BIT_TOGWE]),
    .wr_val (reg_wdata[BIT_TOGVAL]),
    .flip,
    .tog    (data_tog)
  );

  hoe_nak_timer #(.LIM_W(NAK_W)) u_nak (
    .clk, .rst_n,
    .frame_tick,
    .nak_seen,
    .ok       (xact_done),
    .limit    (naklim_q),
    .flag_clr (csr_wr & reg_wdata[BIT_NAKTO]),
    .timeout  (nak_timeout)
  );

  always_comb begin
    csr_view             = csr_q;
    csr_view[BIT_TOGVAL] = data_tog;
    csr_view[BIT_NAKTO]  = nak_timeout;
    csr_view[BIT_NEMPTY] = non_empty;
    csr_view[BIT_PKTRDY] = all_full;
    case (reg_addr)
      ADDR_CSR:  reg_rdata = csr_view;
      ADDR_TYPE: reg_rdata = {8'h00, type_q};
      ADDR_MAXP: reg_rdata = 16'(maxp_q);
      default:   reg_rdata = 16'(naklim_q);
    endcase
  end

  assign tx_pending = non_empty;
  assign tgt_ep     = type_q.ep;
  assign tgt_speed  = type_q.speed;
  assign bulk_sel   = type_q.proto == PROTO_BULK;

  assert_pending_needs_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ready |-> csr_q[BIT_MODE]);
  assert_retire_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xact_done && all_full && !csr_wr) |=> (!all_full && tx_pending) || NBUF == 1);
endmodule

// File: tb/host_out_ep_bench.sv
module host_out_ep_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic ld_valid = 1'b0, ld_ready;
  logic xact_done = 1'b0, nak_seen = 1'b0, frame_tick = 1'b0;
  logic tx_pending, data_tog, nak_timeout, bulk_sel;
  logic [3:0] tgt_ep;
  logic [1:0] tgt_speed;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  host_out_ep #(.NBUF(2), .MAXP_W(11), .NAK_W(16)) u_host_out_ep (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .ld_valid, .ld_ready, .xact_done, .nak_seen, .frame_tick,
    .tx_pending, .data_tog, .nak_timeout, .tgt_ep, .tgt_speed, .bulk_sel
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic load(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ld_valid = 1'b1;
      @(negedge clk); ld_valid = 1'b0;
    end
  endtask

  task automatic ack();
    @(negedge clk); xact_done = 1'b1;
    @(negedge clk); xact_done = 1'b0;
  endtask

  task automatic nak();
    @(negedge clk); nak_seen = 1'b1;
    @(negedge clk); nak_seen = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); frame_tick = 1'b1;
      @(negedge clk); frame_tick = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1", "register reset", 32'(v), 32'h0);
    end
    chk("R1", "toggle reset", 32'(data_tog), 32'h0);
    chk("R1", "pending reset", 32'(tx_pending), 32'h0);
    chk("R1", "timeout reset", 32'(nak_timeout), 32'h0);
    chk("R1", "ld_ready reset", 32'(ld_ready), 32'h0);
  endtask

  task automatic t_regs();
    logic [15:0] v;
    wr(2'd1, 16'h00A5);
    rd(2'd1, v);
    chk("R2", "type readback", 32'(v), 32'hA5);
    chk("R13", "ep", 32'(tgt_ep), 32'h5);
    chk("R13", "speed", 32'(tgt_speed), 32'h2);
    chk("R13", "bulk sel", 32'(bulk_sel), 32'h1);
    wr(2'd1, 16'h0095);
    chk("R13", "non-bulk", 32'(bulk_sel), 32'h0);
    wr(2'd2, 16'hFFFF);
    rd(2'd2, v);
    chk("R2", "maxp truncation", 32'(v), 32'h7FF);
    wr(2'd3, 16'h8000);
    rd(2'd3, v);
    chk("R2", "nak limit", 32'(v), 32'h8000);
    wr(2'd0, 16'hDC00);
    rd(2'd0, v);
    chk("R2", "csr stored bits", 32'(v), 32'hDC00);
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'd4);
  endtask

  task automatic t_load();
    logic [15:0] v;
    chk("R3", "ld_ready off without mode", 32'(ld_ready), 32'h0);
    wr(2'd0, 16'h2000);
    chk("R3", "ld_ready with mode", 32'(ld_ready), 32'h1);
    load(3);
    wr(2'd0, 16'h2001);
    rd(2'd0, v);
    chk("R5", "one committed bits1:0", 32'(v[1:0]), 32'h2);
    chk("R5", "pending", 32'(tx_pending), 32'h1);
    wr(2'd0, 16'h2001);
    rd(2'd0, v);
    chk("R5", "both committed bits1:0", 32'(v[1:0]), 32'h3);
    chk("R3", "ld_ready when full", 32'(ld_ready), 32'h0);
    load(3);
    ack();
    rd(2'd0, v);
    chk("R6", "one retired bits1:0", 32'(v[1:0]), 32'h2);
    chk("R6", "toggle after ack", 32'(data_tog), 32'h1);
    ack();
    chk("R6", "all retired", 32'(tx_pending), 32'h0);
    chk("R6", "toggle after second ack", 32'(data_tog), 32'h0);
    wr(2'd0, 16'hA000);
    load(1);
    chk("R3", "blocked bytes not counted", 32'(tx_pending), 32'h0);
    load(3);
    chk("R4", "autoset at max", 32'(tx_pending), 32'h1);
    wr(2'd0, 16'hA008);
  endtask

  task automatic t_autoset_flush();
    logic [15:0] v;
    chk("R10", "empty before", 32'(tx_pending), 32'h0);
    load(3);
    chk("R4", "no commit below max", 32'(tx_pending), 32'h0);
    load(1);
    chk("R4", "commit at max", 32'(tx_pending), 32'h1);
    load(4);
    rd(2'd0, v);
    chk("R4", "second buffer committed", 32'(v[1:0]), 32'h3);
    wr(2'd0, 16'hA008);
    rd(2'd0, v);
    chk("R10", "first flush", 32'(v[1:0]), 32'h2);
    wr(2'd0, 16'hA008);
    rd(2'd0, v);
    chk("R10", "second flush", 32'(v[1:0]), 32'h0);
    load(2);
    wr(2'd0, 16'hA008);
    load(2);
    chk("R10", "partial count discarded", 32'(tx_pending), 32'h0);
    load(2);
    chk("R10", "count restarted", 32'(tx_pending), 32'h1);
    wr(2'd0, 16'h2008);
  endtask

  task automatic t_toggle();
    logic [15:0] v;
    wr(2'd0, 16'h2100);
    chk("R8", "value without enable", 32'(data_tog), 32'h0);
    wr(2'd0, 16'h2300);
    rd(2'd0, v);
    chk("R8", "guarded write", 32'(data_tog), 32'h1);
    chk("R8", "bit 8 reads toggle", 32'(v[8]), 32'h1);
    chk("R8", "bit 9 reads 0", 32'(v[9]), 32'h0);
    wr(2'd0, 16'h2040);
    rd(2'd0, v);
    chk("R9", "clear strobe", 32'(data_tog), 32'h0);
    chk("R9", "bit 6 reads 0", 32'(v[6]), 32'h0);
    wr(2'd0, 16'h2300);
    wr(2'd0, 16'h2340);
    chk("R9", "clear beats write", 32'(data_tog), 32'h0);
  endtask

  task automatic t_force();
    nak();
    chk("R7", "nak without force", 32'(data_tog), 32'h0);
    wr(2'd0, 16'h2800);
    nak();
    chk("R7", "nak with force", 32'(data_tog), 32'h1);
    ack();
    chk("R7", "ack with force", 32'(data_tog), 32'h0);
    wr(2'd0, 16'h2000);
  endtask

  task automatic t_nak();
    logic [15:0] v;
    wr(2'd3, 16'd3);
    ack();
    nak();
    ticks(2);
    chk("R11", "below limit", 32'(nak_timeout), 32'h0);
    ticks(1);
    chk("R11", "at limit", 32'(nak_timeout), 32'h1);
    ticks(2);
    rd(2'd0, v);
    chk("R12", "sticky", 32'(v[7]), 32'h1);
    wr(2'd0, 16'h2080);
    chk("R12", "write-one clear", 32'(nak_timeout), 32'h0);
    ack();
    nak();
    ticks(2);
    ack();
    nak();
    ticks(2);
    chk("R11", "ack restarts count", 32'(nak_timeout), 32'h0);
    ticks(1);
    chk("R11", "limit after restart", 32'(nak_timeout), 32'h1);
    wr(2'd0, 16'h2080);
    wr(2'd3, 16'd0);
    ack();
    nak();
    ticks(5);
    chk("R11", "zero limit disables", 32'(nak_timeout), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_load();
    t_autoset_flush();
    t_toggle();
    t_force();
    t_nak();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule